// File: doc/BRIEF.md
# Configurable 16-bit Up/Down Timer

A 16-bit binary counter steered by a 16-bit mode word. The counter advances by one on each single-cycle count strobe supplied from outside. The mode word sets the direction. The direction can be fixed up, fixed down, or follow the level of a direction pin with either sense. A gate pin can hold the count off, again with either sense. The timer can wait for an edge on a trigger pin before it runs. It can stop itself when the counter reaches compare register A. Register A works either as a compare register or as a capture register. The counter can be cleared on a compare match or on a capture. An initialize command zeroes the counter and reloads the active compare registers A and B from their buffer inputs.

The trigger, gate and direction pins each pass through a two-flop synchronizer before they are sampled. The mode word is written whole and read back at any time. Its top bit reports whether the counter is running. The polarity of the trigger and gate pins, the capture/compare choice for register A and the capture strobe come from plain control inputs. The block has no streaming data path, so it needs no valid/ready handshake.

Mode word bits:

| Bit | Function |
|-----|----------|
| 15 | running status, read-only |
| 13 | trigger start enable |
| 12 | one-shot enable |
| 11 | clear enable |
| 10 | gate enable |
| 9:8 | direction code |
| 7 | operation enable |
| 6 | initialize, write-only |
| 2:0 | clock-source code, stored only |

Bits 14 and 5:3 read 0.

Top module: `updown_timer16`

## Requirements
- R1: After reset, mode_rdata is 0x0800 (clear enabled, stopped), count, reg_a and reg_b are 0, and ovf and unf are 0.
- R2: Reading the mode word gives bits 13:7 and 2:0 as last written. Bits 14, 6 and 5:3 read 0. Bit 15 reads 1 while running and 0 while stopped. A write with bit 7 = 1 and bit 13 = 0 starts the counter.
- R3: Each accepted strobe changes count by one. The direction depends on bits 9:8. Code 00 counts up and code 01 counts down. Code 10 counts up when dir_pin is high and down when it is low. Code 11 counts up when dir_pin is low and down when it is high.
- R4: Up counting wraps from 0xFFFF to 0x0000 and raises ovf for the one cycle after the wrap. Down counting wraps from 0x0000 to 0xFFFF and raises unf in the same way.
- R5: With bit 10 = 1 and gate_pol = 0, a low gate_pin blocks strobes and a high gate_pin passes them. gate_pol = 1 reverses this.
- R6: With bit 13 = 1, the stopped timer starts on a falling edge of trig_pin when trig_pol = 0 and on a rising edge when trig_pol = 1. Edges of the other direction are ignored. With bit 13 = 0, trigger edges never start the timer.
- R7: With bit 12 = 1 and register A in compare mode (cap_mode = 0), the timer stops when count equals reg_a. It then holds that value and bit 15 falls. With bit 12 = 0, counting continues past the match.
- R8: With bit 11 = 1 and compare mode, a strobe accepted while count equals reg_a sets count to 0. With bit 11 = 0, the count passes through reg_a.
- R9: With cap_mode = 1, cap_stb loads the current count into reg_a. If bit 11 = 1, count goes to 0 as well, and this clear overrides a strobe in the same cycle.
- R10: A mode write with bit 6 = 1 sets count to 0, loads reg_b from cmpb_buf, and in compare mode loads reg_a from cmpa_buf. This overrides a strobe in the same cycle.
- R11: While bit 7 is 0, the timer is stopped and strobes do not change count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| mode_we | input | 1 | mode word write strobe |
| mode_wdata | input | 16 | mode word write value |
| mode_rdata | output | 16 | mode word read value with running status |
| count_stb | input | 1 | single-cycle count strobe |
| trig_pin | input | 1 | external trigger, asynchronous |
| gate_pin | input | 1 | count gate, asynchronous |
| dir_pin | input | 1 | direction control, asynchronous |
| trig_pol | input | 1 | trigger edge select (0 falling, 1 rising) |
| gate_pol | input | 1 | gate sense select (0 high passes, 1 low passes) |
| cap_mode | input | 1 | register A role (0 compare, 1 capture) |
| cap_stb | input | 1 | capture event strobe |
| cmpa_buf | input | 16 | compare A buffer value |
| cmpb_buf | input | 16 | compare B buffer value |
| count | output | 16 | counter value |
| reg_a | output | 16 | register A (compare or captured value) |
| reg_b | output | 16 | active compare register B |
| ovf | output | 1 | up-wrap pulse |
| unf | output | 1 | down-wrap pulse |

## Verification
Two pairs of events can fall in the same cycle: a count strobe with a clearing capture, and a count strobe with an initialize write. The bench raises cap_stb and count_stb together in capture mode with clear enabled. It expects reg_a to hold the count from before the step and count to read 0. It also drives an initialize write while count_stb is high. There it expects count to read 0 and the freshly loaded buffers in reg_a and reg_b, not a stepped value.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int MODE_W = 16;
  localparam int B_RUN  = 15;
  localparam int B_TRG  = 13;
  localparam int B_ONE  = 12;
  localparam int B_CLR  = 11;
  localparam int B_GATE = 10;
  localparam int B_DIRH = 9;
  localparam int B_DIRL = 8;
  localparam int B_EN   = 7;
  localparam int B_INIT = 6;
  localparam logic [MODE_W-1:0] MODE_RST  = 16'h0800;
  localparam logic [MODE_W-1:0] MODE_KEEP = 16'h3F87;

  typedef enum logic [1:0] {
    DIR_UP        = 2'b00,
    DIR_DOWN      = 2'b01,
    DIR_PIN_HI_UP = 2'b10,
    DIR_PIN_LO_UP = 2'b11
  } dir_mode_e;
endpackage

// File: rtl/tmr16_sync.sv
module tmr16_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tmr16_ctrl.sv
module tmr16_ctrl
  import tmr16_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              trig_s,
  input  logic              trig_pol,
  input  logic              hit,
  output logic [MODE_W-1:0] mode_q,
  output logic              run,
  output logic              init_pulse
);
  logic trig_d, trig_edge, trig_fire, en_next, oneshot_stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_d <= 1'b0;
    else        trig_d <= trig_s;
  end

  assign trig_edge    = trig_pol ? (trig_s & ~trig_d) : (~trig_s & trig_d);
  assign trig_fire    = mode_q[B_TRG] & trig_edge;
  assign en_next      = mode_we ? mode_wdata[B_EN] : mode_q[B_EN];
  assign oneshot_stop = run & mode_q[B_ONE] & hit;
  assign init_pulse   = mode_we & mode_wdata[B_INIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= MODE_RST;
    else if (mode_we) mode_q <= mode_wdata & MODE_KEEP;
  end

  // Priority: disable, one-shot stop, trigger start, plain start by write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             run <= 1'b0;
    else if (!en_next)                      run <= 1'b0;
    else if (oneshot_stop)                  run <= 1'b0;
    else if (trig_fire)                     run <= 1'b1;
    else if (mode_we && !mode_wdata[B_TRG]) run <= 1'b1;
  end
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         stb,
  input  logic         gate_ok,
  input  logic         up,
  input  logic         one_en,
  input  logic         clr_en,
  input  logic         cap_mode,
  input  logic         cap_stb,
  input  logic         init,
  input  logic [W-1:0] buf_a,
  input  logic [W-1:0] buf_b,
  output logic [W-1:0] cnt,
  output logic [W-1:0] reg_a,
  output logic [W-1:0] reg_b,
  output logic         hit,
  output logic         ovf,
  output logic         unf
);
  localparam logic [W-1:0] ALL_ONES = '1;

  logic step, cap_clr, match_clr, wrap_up, wrap_dn;

  assign hit       = ~cap_mode & (cnt == reg_a);
  assign step      = run & stb & gate_ok & ~(hit & one_en);
  assign cap_clr   = cap_mode & cap_stb & clr_en;
  assign match_clr = hit & clr_en;
  assign wrap_up   = ~init & ~cap_clr & step & ~match_clr & up & (cnt == ALL_ONES);
  assign wrap_dn   = ~init & ~cap_clr & step & ~match_clr & ~up & (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (init)    cnt <= '0;
    else if (cap_clr) cnt <= '0;
    else if (step) begin
      if (match_clr) cnt <= '0;
      else if (up)   cnt <= cnt + 1'b1;
      else           cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_a <= '0;
      reg_b <= '0;
    end else begin
      if (init && !cap_mode)        reg_a <= buf_a;
      else if (cap_mode && cap_stb) reg_a <= cnt;
      if (init)                     reg_b <= buf_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf <= 1'b0;
      unf <= 1'b0;
    end else begin
      ovf <= wrap_up;
      unf <= wrap_dn;
    end
  end
endmodule

// File: rtl/updown_timer16.sv
module updown_timer16
  import tmr16_pkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_wdata,
  output logic [MODE_W-1:0] mode_rdata,
  input  logic              count_stb,
  input  logic              trig_pin,
  input  logic              gate_pin,
  input  logic              dir_pin,
  input  logic              trig_pol,
  input  logic              gate_pol,
  input  logic              cap_mode,
  input  logic              cap_stb,
  input  logic [W-1:0]      cmpa_buf,
  input  logic [W-1:0]      cmpb_buf,
  output logic [W-1:0]      count,
  output logic [W-1:0]      reg_a,
  output logic [W-1:0]      reg_b,
  output logic              ovf,
  output logic              unf
);
  localparam int NPIN = 3;

  logic [NPIN-1:0]   pins_s;
  logic [MODE_W-1:0] mode_q;
  logic              run, init_pulse, hit, gate_ok, up;
  dir_mode_e         dmode;

  tmr16_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({trig_pin, gate_pin, dir_pin}),
    .q(pins_s)
  );

  tmr16_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .mode_we(mode_we), .mode_wdata(mode_wdata),
    .trig_s(pins_s[2]), .trig_pol(trig_pol), .hit(hit),
    .mode_q(mode_q), .run(run), .init_pulse(init_pulse)
  );

  assign gate_ok = ~mode_q[B_GATE] | (pins_s[1] ^ gate_pol);
  assign dmode   = dir_mode_e'(mode_q[B_DIRH:B_DIRL]);

  always_comb begin
    unique case (dmode)
      DIR_UP:        up = 1'b1;
      DIR_DOWN:      up = 1'b0;
      DIR_PIN_HI_UP: up = pins_s[0];
      DIR_PIN_LO_UP: up = ~pins_s[0];
      default:       up = 1'b1;
    endcase
  end

  tmr16_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n),
    .run(run), .stb(count_stb), .gate_ok(gate_ok), .up(up),
    .one_en(mode_q[B_ONE]), .clr_en(mode_q[B_CLR]),
    .cap_mode(cap_mode), .cap_stb(cap_stb), .init(init_pulse),
    .buf_a(cmpa_buf), .buf_b(cmpb_buf),
    .cnt(count), .reg_a(reg_a), .reg_b(reg_b),
    .hit(hit), .ovf(ovf), .unf(unf)
  );

  assign mode_rdata = {run, mode_q[MODE_W-2:0]};
endmodule

// File: rtl/tmr16_chk.sv
module tmr16_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         mode_we,
  input logic [15:0]  mode_wdata,
  input logic [15:0]  mode_rdata,
  input logic         cap_mode,
  input logic         cap_stb,
  input logic [W-1:0] cmpb_buf,
  input logic [W-1:0] count,
  input logic [W-1:0] reg_a,
  input logic [W-1:0] reg_b,
  input logic         ovf,
  input logic         unf
);
  assert_zero_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_rdata[14] == 1'b0 && mode_rdata[6] == 1'b0 && mode_rdata[5:3] == 3'b000);

  assert_ovf_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (count == '0 && !unf));

  assert_unf_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    unf |-> (count == '1));

  assert_oneshot_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_rdata[15] && mode_rdata[12] && !cap_mode && count == reg_a) |=> !mode_rdata[15]);

  assert_init_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_we && mode_wdata[6]) |=> (count == '0 && reg_b == $past(cmpb_buf)));

  assert_disabled_stopped_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_rdata[7] |-> !mode_rdata[15]);

  assert_stopped_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_rdata[15] && !mode_we && !cap_stb) |=> $stable(count));
endmodule

bind updown_timer16 tmr16_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
  .mode_rdata(mode_rdata), .cap_mode(cap_mode), .cap_stb(cap_stb),
  .cmpb_buf(cmpb_buf), .count(count), .reg_a(reg_a), .reg_b(reg_b),
  .ovf(ovf), .unf(unf)
);

// File: tb/test_updown_timer16.sv
`timescale 1ns/1ps
module test_updown_timer16;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_we = 1'b0;
  logic [15:0] mode_wdata = '0;
  logic [15:0] mode_rdata;
  logic        count_stb = 1'b0;
  logic        trig_pin = 1'b1, gate_pin = 1'b0, dir_pin = 1'b0;
  logic        trig_pol = 1'b0, gate_pol = 1'b0;
  logic        cap_mode = 1'b0, cap_stb = 1'b0;
  logic [15:0] cmpa_buf = 16'h0005, cmpb_buf = 16'h1234;
  logic [15:0] count, reg_a, reg_b;
  logic        ovf, unf;

  int  n_chk = 0, n_fail = 0;
  bit  done = 1'b0;

  typedef enum int {K_CNT, K_MODE, K_RA, K_RB, K_OVF, K_UNF} kind_e;
  typedef struct { kind_e kind; logic [15:0] exp; string tag; } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  updown_timer16 i_updown_timer16 (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .mode_rdata(mode_rdata), .count_stb(count_stb), .trig_pin(trig_pin),
    .gate_pin(gate_pin), .dir_pin(dir_pin), .trig_pol(trig_pol),
    .gate_pol(gate_pol), .cap_mode(cap_mode), .cap_stb(cap_stb),
    .cmpa_buf(cmpa_buf), .cmpb_buf(cmpb_buf), .count(count), .reg_a(reg_a),
    .reg_b(reg_b), .ovf(ovf), .unf(unf)
  );

  // Monitor: compares every queued expectation against the live outputs.
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = sb.pop_front();
      case (it.kind)
        K_CNT:   act = count;
        K_MODE:  act = mode_rdata;
        K_RA:    act = reg_a;
        K_RB:    act = reg_b;
        K_OVF:   act = {15'd0, ovf};
        default: act = {15'd0, unf};
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: got 0x%04h expected 0x%04h", it.tag, act, it.exp);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_v(input kind_e k, input logic [15:0] v, input string tag);
    item_t it;
    it.kind = k; it.exp = v; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic wr_mode(input logic [15:0] v);
    mode_we = 1'b1; mode_wdata = v;
    tick(1);
    mode_we = 1'b0;
  endtask

  task automatic strobe(input int n);
    for (int i = 0; i < n; i++) begin
      count_stb = 1'b1;
      tick(1);
      count_stb = 1'b0;
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    expect_v(K_MODE, 16'h0800, "R1 mode");
    expect_v(K_CNT, 16'h0000, "R1 count");
    expect_v(K_RA, 16'h0000, "R1 reg_a");
    expect_v(K_OVF, 16'h0000, "R1 ovf");
    tick(1);

    // R2 start, R3 up then down
    wr_mode(16'h0080);
    expect_v(K_MODE, 16'h8080, "R2 running readback");
    strobe(3);
    expect_v(K_CNT, 16'h0003, "R3 up count");
    wr_mode(16'h0180);
    strobe(1);
    expect_v(K_CNT, 16'h0002, "R3 down count");

    // R10 init, R2 bit 6 reads 0
    wr_mode(16'h00C0);
    expect_v(K_CNT, 16'h0000, "R10 init count");
    expect_v(K_RA, 16'h0005, "R10 reg_a load");
    expect_v(K_RB, 16'h1234, "R10 reg_b load");
    expect_v(K_MODE, 16'h8080, "R2 init bit reads 0");

    // R4 wraps
    wr_mode(16'h0180);
    strobe(1);
    expect_v(K_CNT, 16'hFFFF, "R4 down wrap");
    expect_v(K_UNF, 16'h0001, "R4 unf pulse");
    tick(1);
    expect_v(K_UNF, 16'h0000, "R4 unf one cycle");
    wr_mode(16'h0080);
    strobe(1);
    expect_v(K_CNT, 16'h0000, "R4 up wrap");
    expect_v(K_OVF, 16'h0001, "R4 ovf pulse");

    // R3 pin-steered direction
    wr_mode(16'h0280);
    dir_pin = 1'b1; tick(3);
    strobe(2);
    expect_v(K_CNT, 16'h0002, "R3 code10 pin high up");
    dir_pin = 1'b0; tick(3);
    strobe(1);
    expect_v(K_CNT, 16'h0001, "R3 code10 pin low down");
    wr_mode(16'h0380);
    strobe(1);
    expect_v(K_CNT, 16'h0002, "R3 code11 pin low up");

    // R5 gating
    wr_mode(16'h0480);
    gate_pol = 1'b0; gate_pin = 1'b0; tick(3);
    strobe(2);
    expect_v(K_CNT, 16'h0002, "R5 pol0 low blocks");
    gate_pin = 1'b1; tick(3);
    strobe(1);
    expect_v(K_CNT, 16'h0003, "R5 pol0 high passes");
    gate_pol = 1'b1; tick(1);
    strobe(1);
    expect_v(K_CNT, 16'h0003, "R5 pol1 high blocks");
    gate_pin = 1'b0; tick(3);
    strobe(1);
    expect_v(K_CNT, 16'h0004, "R5 pol1 low passes");

    // R8 clear on match, and pass-through when clear is off
    wr_mode(16'h08C0);
    strobe(5);
    expect_v(K_CNT, 16'h0005, "R8 reaches match");
    strobe(1);
    expect_v(K_CNT, 16'h0000, "R8 clear on match");
    wr_mode(16'h00C0);
    strobe(6);
    expect_v(K_CNT, 16'h0006, "R8 no clear passes match");

    // R11 disabled
    wr_mode(16'h0000);
    expect_v(K_MODE, 16'h0000, "R11 stopped status");
    strobe(2);
    expect_v(K_CNT, 16'h0006, "R11 no count when disabled");
    wr_mode(16'h0040);
    expect_v(K_CNT, 16'h0000, "R10 init while disabled");

    // R6 trigger falling edge start, R7 one-shot stop
    trig_pol = 1'b0;
    wr_mode(16'h30C0);
    expect_v(K_MODE, 16'h3080, "R6 waits for trigger");
    strobe(1);
    expect_v(K_CNT, 16'h0000, "R6 no count before trigger");
    trig_pin = 1'b0; tick(4);
    expect_v(K_MODE, 16'hB080, "R6 falling edge starts");
    strobe(7);
    expect_v(K_CNT, 16'h0005, "R7 one-shot holds match");
    expect_v(K_MODE, 16'h3080, "R7 one-shot stopped");
    trig_pin = 1'b1; tick(4);
    expect_v(K_MODE, 16'h3080, "R6 rising ignored at pol0");

    // R6 rising edge with pol 1
    trig_pol = 1'b1;
    wr_mode(16'h30C0);
    trig_pin = 1'b0; tick(4);
    expect_v(K_MODE, 16'h3080, "R6 falling ignored at pol1");
    trig_pin = 1'b1; tick(4);
    expect_v(K_MODE, 16'hB080, "R6 rising edge starts");

    // R6 trigger disabled: edges do not restart after one-shot stop
    wr_mode(16'h10C0);
    strobe(6);
    expect_v(K_MODE, 16'h1080, "R7 stop without trigger");
    trig_pin = 1'b0; tick(4);
    trig_pin = 1'b1; tick(4);
    expect_v(K_MODE, 16'h1080, "R6 disabled trigger ignored");
    strobe(1);
    expect_v(K_CNT, 16'h0005, "R6 disabled trigger no count");

    // R9 capture with clear against a simultaneous strobe
    cap_mode = 1'b1;
    wr_mode(16'h0880);
    strobe(2);
    expect_v(K_CNT, 16'h0007, "R9 pre-capture count");
    cap_stb = 1'b1; count_stb = 1'b1;
    tick(1);
    cap_stb = 1'b0; count_stb = 1'b0;
    expect_v(K_RA, 16'h0007, "R9 captured pre-step value");
    expect_v(K_CNT, 16'h0000, "R9 clear beats step");
    wr_mode(16'h0080);
    strobe(3);
    cap_stb = 1'b1;
    tick(1);
    cap_stb = 1'b0;
    expect_v(K_RA, 16'h0003, "R9 capture without clear");
    expect_v(K_CNT, 16'h0003, "R9 count kept");

    // R10 init beats a strobe in the same cycle
    cap_mode = 1'b0;
    cmpa_buf = 16'h0009; cmpb_buf = 16'h0077;
    count_stb = 1'b1;
    wr_mode(16'h00C0);
    count_stb = 1'b0;
    expect_v(K_CNT, 16'h0000, "R10 init beats step");
    expect_v(K_RA, 16'h0009, "R10 reg_a reload");
    expect_v(K_RB, 16'h0077, "R10 reg_b reload");
    strobe(1);
    expect_v(K_CNT, 16'h0001, "R3 counts after init");

    tick(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule